// File: doc/BRIEF.md
# LIN Slave Header Synchronizer

This block sits beside the receiver of a LIN slave node and follows the three parts of a frame header as they arrive: the break, the synch character and the identifier. A break-detect strobe from the receiver starts a synch-analysis phase, and a flag stays high for the whole of that phase. Software can abort the phase at any time. While the phase runs, and if automatic resynchronization is on, the block watches the sampled receive line for falling edges. A synch character of 0x55 has five falling edges, eight bit times apart from the first to the last. The block times that span in system clocks and divides it by eight. The result becomes the new baud divider.

The divider can also be written by software. A mode bit chooses whether a written value takes effect at once or waits for the next received character. A measured value always beats a software value in the same cycle. Loading a measured value also clears the mode bit. When the identifier character arrives, a sticky header flag is set. This flag drives an interrupt through an enable bit. All of this runs only in slave mode.

Top module: `lin_hdr_sync`

## Requirements
- R1: After reset, `div_o` is 0 and `sync_busy_o`, `hdr_flag_o`, `hdr_irq_o` and `upd_defer_o` are all 0.
- R2: In slave mode a `brk_det_i` pulse sets `sync_busy_o` from the next cycle on. A software abort in the same cycle as the break takes precedence only if the block is already in synch analysis. In master mode a break has no effect.
- R3: When `sync_abort_i` is high during synch analysis, `sync_busy_o` falls on the next cycle and the block goes back to idle. The next two received characters then do not set `hdr_flag_o`.
- R4: During synch analysis, an `rxne_i` pulse ends the phase, so `sync_busy_o` is 0 on the next cycle. The next `rxne_i` pulse is taken as the identifier and sets `hdr_flag_o` on the following cycle.
- R5: `hdr_flag_o` stays 1 until a `hdr_clr_i` pulse. A set in the same cycle as a clear wins.
- R6: `hdr_irq_o` is 1 exactly while `hdr_flag_o` and `hdr_irq_en_i` are both 1.
- R7: With `auto_resync_i` at 1 during synch analysis, let T be the number of clocks from the first falling edge of `rx_i` to the fifth. `div_o` becomes floor(T/8) on the cycle after the fifth edge. With `auto_resync_i` at 0, no measured value is loaded.
- R8: With `upd_defer_o` at 0, a `div_wr_i` pulse puts `div_wdata_i` on `div_o` on the next cycle.
- R9: With `upd_defer_o` at 1, a written value is held back and `div_o` does not change. The held value appears on the cycle after the next `rxne_i` pulse.
- R10: Loading a measured divider clears `upd_defer_o` and discards any held value. A software write in the same cycle as the load is lost.
- R11: While `slave_mode_i` is 0, the block is held idle. `sync_busy_o` is 0 from the next cycle on, and no measured divider is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Receive line, already synchronized to clk |
| brk_det_i | input | 1 | One-cycle strobe: break detected |
| rxne_i | input | 1 | One-cycle strobe: a character has been received |
| slave_mode_i | input | 1 | 1 = slave mode, 0 = master mode |
| auto_resync_i | input | 1 | Enables baud measurement during synch analysis |
| hdr_irq_en_i | input | 1 | Header interrupt enable |
| sync_abort_i | input | 1 | Software write of 0 to the synch-analysis flag |
| hdr_clr_i | input | 1 | Software write of 0 to the header flag |
| div_wr_i | input | 1 | Software write strobe for the divider |
| div_wdata_i | input | DIV_W | Divider value written by software |
| defer_wr_i | input | 1 | Software write strobe for the update-mode bit |
| defer_wdata_i | input | 1 | Update-mode value: 1 = defer to next character |
| div_o | output | DIV_W | Current baud divider |
| upd_defer_o | output | 1 | Update-mode bit |
| sync_busy_o | output | 1 | Synch analysis in progress |
| hdr_flag_o | output | 1 | Header detected (sticky) |
| hdr_irq_o | output | 1 | Header interrupt |

## Verification
The assertions assume that `rx_i` is already synchronous to `clk`. They also assume that every strobe lasts exactly one cycle, so a single `rxne_i` pulse is counted once. The properties for the measured load take the span to fit the timer, so no saturation is in play. The stimulus builds each character bit by bit with a fixed number of clocks per bit. It raises every strobe for one cycle at a falling clock edge. One software write is lined up on purpose with the fifth synch edge, so that the priority of the measured load is exercised without breaking the one-cycle strobe rule.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_SYNC  = 2'd1,
    HS_IDENT = 2'd2
  } hdr_state_e;

  // measured span (clocks over eight bit times) to per-bit divider
  function automatic logic [31:0] span_to_div(input logic [31:0] span,
                                              input int unsigned shift);
    return span >> shift;
  endfunction

endpackage

// File: rtl/lin_edge_timer.sv
module lin_edge_timer #(
  parameter int EDGES = 5,
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             arm_i,
  input  logic             restart_i,
  output logic             fall_o,
  output logic             done_o,
  output logic [CNT_W-1:0] span_o
);
  localparam int ECW = $clog2(EDGES + 1);
  localparam logic [ECW-1:0] LAST = ECW'(EDGES - 1);
  localparam logic [ECW-1:0] FULL = ECW'(EDGES);

  logic             rx_q;
  logic [ECW-1:0]   ecnt_q;
  logic [CNT_W-1:0] tmr_q;

  assign fall_o = rx_q & ~rx_i;
  assign done_o = arm_i & ~restart_i & fall_o & (ecnt_q == LAST);
  assign span_o = tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= 1'b1;
      ecnt_q <= '0;
      tmr_q  <= '0;
    end else begin
      rx_q <= rx_i;
      if (!arm_i || restart_i) begin
        ecnt_q <= '0;
        tmr_q  <= '0;
      end else begin
        if (fall_o && ecnt_q != FULL) ecnt_q <= ecnt_q + 1'b1;
        if (fall_o && ecnt_q == '0) tmr_q <= CNT_W'(1);
        else if (ecnt_q != '0 && ecnt_q != FULL)
          tmr_q <= (&tmr_q) ? tmr_q : tmr_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lin_hdr_fsm.sv
module lin_hdr_fsm
  import lin_hdr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slave_i,
  input  logic brk_i,
  input  logic rxne_i,
  input  logic abort_i,
  input  logic hdr_clr_i,
  output logic sync_busy_o,
  output logic hdr_flag_o,
  output logic hdr_set_o
);
  hdr_state_e state_q, state_d;
  logic       hdr_q;

  always_comb begin
    state_d = state_q;
    if (!slave_i) state_d = HS_IDLE;
    else if (abort_i && state_q == HS_SYNC) state_d = HS_IDLE;
    else if (brk_i) state_d = HS_SYNC;
    else if (rxne_i) begin
      case (state_q)
        HS_SYNC:  state_d = HS_IDENT;
        HS_IDENT: state_d = HS_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  assign hdr_set_o   = slave_i & ~brk_i & rxne_i & (state_q == HS_IDENT);
  assign sync_busy_o = (state_q == HS_SYNC);
  assign hdr_flag_o  = hdr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      hdr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (hdr_set_o) hdr_q <= 1'b1;
      else if (hdr_clr_i) hdr_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lin_div_ctrl.sv
module lin_div_ctrl #(
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync_ld_i,
  input  logic [DIV_W-1:0] meas_i,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] wdata_i,
  input  logic             rxne_i,
  input  logic             defer_wr_i,
  input  logic             defer_wdata_i,
  output logic [DIV_W-1:0] div_o,
  output logic             defer_o
);
  logic [DIV_W-1:0] div_q, pend_q;
  logic             pend_v_q, defer_q;

  assign div_o   = div_q;
  assign defer_o = defer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= DIV_RST;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      defer_q  <= 1'b0;
    end else if (resync_ld_i) begin
      div_q    <= meas_i;
      pend_v_q <= 1'b0;
      defer_q  <= 1'b0;
    end else begin
      if (defer_wr_i) defer_q <= defer_wdata_i;
      if (wr_i && !defer_q) begin
        div_q    <= wdata_i;
        pend_v_q <= 1'b0;
      end else if (rxne_i && pend_v_q) begin
        div_q    <= pend_q;
        pend_v_q <= 1'b0;
      end
      if (wr_i && defer_q) begin
        pend_q   <= wdata_i;
        pend_v_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lin_hdr_sync.sv
module lin_hdr_sync
  import lin_hdr_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int EDGES      = 5,
  parameter int SPAN_SHIFT = 3,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             brk_det_i,
  input  logic             rxne_i,
  input  logic             slave_mode_i,
  input  logic             auto_resync_i,
  input  logic             hdr_irq_en_i,
  input  logic             sync_abort_i,
  input  logic             hdr_clr_i,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             defer_wr_i,
  input  logic             defer_wdata_i,
  output logic [DIV_W-1:0] div_o,
  output logic             upd_defer_o,
  output logic             sync_busy_o,
  output logic             hdr_flag_o,
  output logic             hdr_irq_o
);
  localparam int CNT_W = DIV_W + SPAN_SHIFT;

  // internal events, named for the checker
  logic             fall_w;
  logic             arm_w;
  logic             resync_ld_w;
  logic             hdr_set_w;
  logic [CNT_W-1:0] span_w;
  logic [DIV_W-1:0] meas_div_w;
  logic             sync_busy_w;

  assign arm_w      = slave_mode_i & sync_busy_w & auto_resync_i & ~sync_abort_i;
  assign meas_div_w = DIV_W'(span_to_div(32'(span_w), SPAN_SHIFT));

  lin_edge_timer #(.EDGES(EDGES), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_i      (rx_i),
    .arm_i     (arm_w),
    .restart_i (brk_det_i),
    .fall_o    (fall_w),
    .done_o    (resync_ld_w),
    .span_o    (span_w)
  );

  lin_hdr_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .slave_i     (slave_mode_i),
    .brk_i       (brk_det_i),
    .rxne_i      (rxne_i),
    .abort_i     (sync_abort_i),
    .hdr_clr_i   (hdr_clr_i),
    .sync_busy_o (sync_busy_w),
    .hdr_flag_o  (hdr_flag_o),
    .hdr_set_o   (hdr_set_w)
  );

  lin_div_ctrl #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_div (
    .clk           (clk),
    .rst_n         (rst_n),
    .resync_ld_i   (resync_ld_w),
    .meas_i        (meas_div_w),
    .wr_i          (div_wr_i),
    .wdata_i       (div_wdata_i),
    .rxne_i        (rxne_i),
    .defer_wr_i    (defer_wr_i),
    .defer_wdata_i (defer_wdata_i),
    .div_o         (div_o),
    .defer_o       (upd_defer_o)
  );

  assign sync_busy_o = sync_busy_w;
  assign hdr_irq_o   = hdr_flag_o & hdr_irq_en_i;

endmodule

// File: rtl/lin_hdr_sync_chk.sv
module lin_hdr_sync_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slave_mode_i,
  input logic             brk_det_i,
  input logic             sync_abort_i,
  input logic             rxne_i,
  input logic             hdr_clr_i,
  input logic             div_wr_i,
  input logic [DIV_W-1:0] div_wdata_i,
  input logic             sync_busy_o,
  input logic             hdr_flag_o,
  input logic             upd_defer_o,
  input logic [DIV_W-1:0] div_o,
  input logic             hdr_set_w,
  input logic             resync_ld_w,
  input logic [DIV_W-1:0] meas_div_w
);
  // R2
  brk_enters_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode_i && brk_det_i && !(sync_busy_o && sync_abort_i)) |=> sync_busy_o);

  // R11
  master_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode_i |=> !sync_busy_o);

  // R3
  abort_exits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_busy_o && sync_abort_i) |=> !sync_busy_o);

  // R4
  hdr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_set_w |=> hdr_flag_o);

  // R5
  hdr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_flag_o && !hdr_clr_i) |=> hdr_flag_o);

  // R7
  resync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_ld_w |=> (div_o == $past(meas_div_w)));

  // R10
  resync_clears_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_ld_w |=> !upd_defer_o);

  // R8
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr_i && !upd_defer_o && !resync_ld_w) |=> (div_o == $past(div_wdata_i)));

  // R9
  div_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_wr_i && !rxne_i && !resync_ld_w) |=> $stable(div_o));

endmodule

bind lin_hdr_sync lin_hdr_sync_chk #(.DIV_W(DIV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slave_mode_i (slave_mode_i),
  .brk_det_i    (brk_det_i),
  .sync_abort_i (sync_abort_i),
  .rxne_i       (rxne_i),
  .hdr_clr_i    (hdr_clr_i),
  .div_wr_i     (div_wr_i),
  .div_wdata_i  (div_wdata_i),
  .sync_busy_o  (sync_busy_o),
  .hdr_flag_o   (hdr_flag_o),
  .upd_defer_o  (upd_defer_o),
  .div_o        (div_o),
  .hdr_set_w    (hdr_set_w),
  .resync_ld_w  (resync_ld_w),
  .meas_div_w   (meas_div_w)
);

// File: tb/test_lin_hdr_sync.sv
module test_lin_hdr_sync;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1, brk = 1'b0, rxne = 1'b0, slave = 1'b1, ares = 1'b1;
  logic        ien = 1'b0, abort = 1'b0, hclr = 1'b0, dwr = 1'b0;
  logic [15:0] wdat = 16'h0;
  logic        dfw = 1'b0, dfd = 1'b0;
  logic [15:0] div;
  logic        dfr, busy, hflag, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lin_hdr_sync i_lin_hdr_sync (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .brk_det_i(brk), .rxne_i(rxne),
    .slave_mode_i(slave), .auto_resync_i(ares), .hdr_irq_en_i(ien),
    .sync_abort_i(abort), .hdr_clr_i(hclr), .div_wr_i(dwr), .div_wdata_i(wdat),
    .defer_wr_i(dfw), .defer_wdata_i(dfd), .div_o(div), .upd_defer_o(dfr),
    .sync_busy_o(busy), .hdr_flag_o(hflag), .hdr_irq_o(irq)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_st;      // 0 idle, 1 synch analysis, 2 waiting identifier
  bit          m_rxq;
  int          m_nf;
  longint      m_t0, cyc;
  logic [15:0] m_div, m_pend;
  bit          m_pv, m_def, m_hdr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rxq = 1; m_nf = 0; m_t0 = 0; cyc = 0;
      m_div = 0; m_pend = 0; m_pv = 0; m_def = 0; m_hdr = 0;
    end else begin
      bit fall, arm, rs, hset;
      logic [15:0] meas;
      fall = m_rxq && !rx;
      m_rxq = rx;
      arm = slave && (m_st == 1) && ares && !abort;
      rs = 0; meas = 0;
      if (!arm || brk) m_nf = 0;
      else if (fall) begin
        if (m_nf == 0) m_t0 = cyc;
        if (m_nf == 4) begin rs = 1; meas = 16'((cyc - m_t0) / 8); end
        if (m_nf < 5) m_nf++;
      end
      hset = slave && !brk && (m_st == 2) && rxne;
      if (!slave) m_st = 0;
      else if (abort && m_st == 1) m_st = 0;
      else if (brk) m_st = 1;
      else if (rxne && m_st == 1) m_st = 2;
      else if (rxne && m_st == 2) m_st = 0;
      if (hset) m_hdr = 1; else if (hclr) m_hdr = 0;
      if (rs) begin
        m_div = meas; m_pv = 0; m_def = 0;
      end else begin
        bit old_def;
        old_def = m_def;
        if (dwr && !old_def) begin m_div = wdat; m_pv = 0; end
        else if (rxne && m_pv) begin m_div = m_pend; m_pv = 0; end
        if (dwr && old_def) begin m_pend = wdat; m_pv = 1; end
        if (dfw) m_def = dfd;
      end
      cyc++;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check("div R7 R8 R9 R10", div, m_div);
      check("sync flag R2 R3 R4 R11", busy, m_st == 1);
      check("header flag R4 R5", hflag, m_hdr);
      check("irq R6", irq, m_hdr && ien);
      check("defer bit R10", dfr, m_def);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_break(input int b);
    rx = 0; tick(13 * b);
    rx = 1; brk = 1; tick(1); brk = 0; tick(b - 1);
  endtask

  task automatic send_char(input logic [7:0] d, input int b, input int extra,
                           input bit wr_last, input logic [15:0] wv);
    rx = 0; tick(b);
    for (int i = 0; i < 8; i++) begin
      if (i == 7) tick(extra);
      rx = d[i];
      if (i == 7 && wr_last) begin dwr = 1; wdat = wv; end
      tick(1); dwr = 0; tick(b - 1);
    end
    rx = 1; tick(b);
    rxne = 1; tick(1); rxne = 0;
  endtask

  task automatic pulse_rxne();
    rxne = 1; tick(1); rxne = 0; tick(1);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(1);
    // R1 reset state
    check("R1 div", div, 0); check("R1 sync", busy, 0);
    check("R1 hdr", hflag, 0); check("R1 irq", irq, 0); check("R1 defer", dfr, 0);

    // R8 immediate write
    dwr = 1; wdat = 16'h0042; tick(1); dwr = 0;
    check("R8 immediate write", div, 16'h0042);

    // full header, measured bit time 10
    ien = 1;
    send_break(10);
    check("R2 break enters synch", busy, 1);
    send_char(8'h55, 10, 0, 0, 0);
    check("R4 synch flag ends", busy, 0);
    check("R7 measured divider", div, 10);
    send_char(8'h3C, 10, 0, 0, 0);
    check("R4 header flag", hflag, 1);
    check("R6 irq enabled", irq, 1);
    ien = 0; tick(1);
    check("R6 irq masked", irq, 0);
    tick(5);
    check("R5 flag held", hflag, 1);
    hclr = 1; tick(1); hclr = 0;
    check("R5 flag cleared", hflag, 0);

    // R7 floor on an uneven span
    send_break(9);
    send_char(8'h55, 9, 7, 0, 0);
    check("R7 floor of span", div, (8 * 9 + 7) / 8);
    send_char(8'h11, 9, 0, 0, 0);
    hclr = 1; tick(1); hclr = 0;

    // R7 without automatic resynchronization
    ares = 0;
    send_break(12);
    send_char(8'h55, 12, 0, 0, 0);
    check("R7 no load when disabled", div, 9);
    send_char(8'h22, 12, 0, 0, 0);
    check("R4 header without resync", hflag, 1);
    hclr = 1; tick(1); hclr = 0; ares = 1;

    // R9 deferred write
    dfw = 1; dfd = 1; tick(1); dfw = 0;
    dwr = 1; wdat = 16'h1234; tick(1); dwr = 0; tick(4);
    check("R9 held back", div, 9);
    pulse_rxne();
    check("R9 applied at rxne", div, 16'h1234);

    // R10 measured load clears defer and beats a same-cycle write
    check("R10 defer still set", dfr, 1);
    dwr = 1; wdat = 16'h5555; tick(1); dwr = 0;
    send_break(11);
    send_char(8'h55, 11, 0, 1, 16'h7777);
    check("R10 measured wins", div, 11);
    check("R10 defer cleared", dfr, 0);
    send_char(8'h33, 11, 0, 0, 0);
    check("R10 pending discarded", div, 11);
    hclr = 1; tick(1); hclr = 0;

    // R3 abort
    send_break(10);
    abort = 1; tick(1); abort = 0;
    check("R3 abort clears synch", busy, 0);
    send_char(8'h55, 10, 0, 0, 0);
    send_char(8'h44, 10, 0, 0, 0);
    check("R3 no header after abort", hflag, 0);
    check("R3 no load after abort", div, 11);

    // R11 / R2 master mode
    slave = 0; tick(1);
    brk = 1; tick(1); brk = 0;
    check("R2 break ignored in master", busy, 0);
    send_char(8'h55, 8, 0, 0, 0);
    check("R11 no load in master", div, 11);
    slave = 1; send_break(8);
    slave = 0; tick(1);
    check("R11 slave drop forces idle", busy, 0);
    slave = 1; tick(4);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule